// File: doc/BRIEF.md
# Multi-Queue Pin Interrupt Aggregator

This block drives one level-sensitive interrupt pin for a storage controller that serves several completion queues. It keeps the head and tail index of every queue. It counts how many interrupt-enabled queues hold entries that the host has not yet consumed. It also keeps a 32-bit status bitmap indexed by interrupt vector. Three per-cycle event ports carry the queue traffic: a post event moves a queue's tail, a doorbell event moves its head, and a delete event frees the queue. Two one-cycle strobes set or clear a per-vector mask.

A queue is pending whenever its head and tail differ. When one queue drains, the block asks for a deassert. That request clears the queue's vector bit only if no counted queue is still pending anywhere, so draining one queue cannot drop the pin while another queue still needs service. Polled queues, whose enable bit is low, never take part in the count, the bitmap or the pin.

Top module: `pinirq_aggr`

## Requirements
- R1: After reset the pending-queue count is 0, the status bitmap is 0, the pin is low, the error flag is low, and every queue has head = tail = 0.
- R2: A post that turns an empty interrupt-enabled queue non-empty does two things at the next clock edge. It adds 1 to the count, and it sets the status bit whose index is that queue's vector.
- R3: A post to an interrupt-enabled queue that is already non-empty leaves the count unchanged and sets, or keeps set, the queue's vector bit.
- R4: A doorbell that takes an interrupt-enabled queue from non-empty to empty takes 1 from the count and raises a deassert request. A doorbell that leaves the queue non-empty, or that lands on a queue that is already empty, changes nothing.
- R5: A deassert request clears the requesting queue's vector bit only when the count after the update is 0. Otherwise every status bit stays as it was.
- R6: Deleting an interrupt-enabled queue that still holds entries takes 1 from the count. Any delete of an enabled queue, empty or not, raises a deassert request. After a delete the queue's head and tail are both 0.
- R7: A queue whose enable bit is low (polled) never changes the count, never sets a status bit and never raises a deassert request.
- R8: The pin is a register equal to the OR of (status AND NOT mask), and it updates on the same edge as the status. The mask-set strobe sets the mask bit at the given vector and the mask-clear strobe clears it. If both strobes name the same vector in one cycle, set wins.
- R9: A decrement that would take the count below 0 is dropped. It then sets an error flag that stays set until reset.
- R10: Within one cycle the events are applied in the order post, then doorbell, then delete. A deassert clear overrides a status set made in the same cycle.
- R11: Queue q takes its vector from bits [5q+4:5q] of `q_vec` and its enable from bit q of `q_ien`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Post event: new tail for one queue |
| post_qid | input | 4 | Queue addressed by the post event |
| post_tail | input | 8 | New tail index |
| db_valid | input | 1 | Head doorbell event |
| db_qid | input | 4 | Queue addressed by the doorbell |
| db_head | input | 8 | New head index |
| del_valid | input | 1 | Queue delete event |
| del_qid | input | 4 | Queue being deleted |
| q_ien | input | 16 | Per-queue interrupt enable |
| q_vec | input | 80 | Per-queue vector number, 5 bits per queue |
| mask_set_valid | input | 1 | Mask-set strobe |
| mask_set_vec | input | 5 | Vector to mask |
| mask_clr_valid | input | 1 | Mask-clear strobe |
| mask_clr_vec | input | 5 | Vector to unmask |
| irq_status | output | 32 | Vector status bitmap |
| irq_pin | output | 1 | Level interrupt pin |
| pend_cnt | output | 5 | Count of counted pending queues |
| cnt_err | output | 1 | Sticky counter underflow flag |

## Verification
The assertions take the configuration inputs as stable whenever a queue is posted to or drained. Only the underflow case breaks that rule, and it does so on purpose by enabling a queue that already holds entries. The polled-queue check expects the post event to arrive alone in its cycle, and the stimulus drives such posts with no doorbell or delete beside them. Only one cycle carries a post and a doorbell together; it targets a single queue to exercise the ordering rule. Queue numbers are always inside the queue range, and every strobe and event lasts exactly one cycle, driven between clock edges.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int NUM_VEC = 32;
  localparam int VEC_W   = 5;

  // one-hot bit of the status bitmap for a vector number
  function automatic logic [NUM_VEC-1:0] vec_bit(input logic [VEC_W-1:0] v);
    return NUM_VEC'(1) << v;
  endfunction

  // a queue is pending while its indices differ
  function automatic logic is_pending(input logic [31:0] head, input logic [31:0] tail);
    return head != tail;
  endfunction

  // counter update: increments first, decrements clamp at zero
  function automatic int unsigned cnt_apply(input int unsigned cur,
                                            input int unsigned inc,
                                            input int unsigned dec);
    return (dec > cur + inc) ? 0 : cur + inc - dec;
  endfunction

  function automatic logic cnt_underflow(input int unsigned cur,
                                         input int unsigned inc,
                                         input int unsigned dec);
    return dec > cur + inc;
  endfunction
endpackage

// File: rtl/pinirq_cq_track.sv
module pinirq_cq_track #(
  parameter int NUM_Q = 16,
  parameter int IDX_W = 8,
  parameter int QID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_valid,
  input  logic [QID_W-1:0] post_qid,
  input  logic [IDX_W-1:0] post_tail,
  input  logic             db_valid,
  input  logic [QID_W-1:0] db_qid,
  input  logic [IDX_W-1:0] db_head,
  input  logic             del_valid,
  input  logic [QID_W-1:0] del_qid,
  input  logic [NUM_Q-1:0] q_ien,
  output logic [NUM_Q-1:0] rise_vec,
  output logic [NUM_Q-1:0] hit_vec,
  output logic [NUM_Q-1:0] drain_vec,
  output logic [NUM_Q-1:0] delp_vec,
  output logic [NUM_Q-1:0] deassert_vec
);
  import pinirq_pkg::*;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [IDX_W-1:0] head_r, tail_r;
    logic [IDX_W-1:0] tail_a, head_b;
    logic post_hit, db_hit, del_hit;
    logic was_pend, pend_post, pend_fin;

    assign post_hit = post_valid && (post_qid == QID_W'(q));
    assign db_hit   = db_valid   && (db_qid   == QID_W'(q));
    assign del_hit  = del_valid  && (del_qid  == QID_W'(q));

    // post first, then doorbell
    assign tail_a    = post_hit ? post_tail : tail_r;
    assign head_b    = db_hit ? db_head : head_r;
    assign was_pend  = is_pending(32'(head_r), 32'(tail_r));
    assign pend_post = is_pending(32'(head_r), 32'(tail_a));
    assign pend_fin  = is_pending(32'(head_b), 32'(tail_a));

    assign rise_vec[q]     = q_ien[q] && post_hit && !was_pend && pend_post;
    assign hit_vec[q]      = q_ien[q] && post_hit && pend_post;
    assign drain_vec[q]    = q_ien[q] && db_hit && pend_post && !pend_fin;
    assign delp_vec[q]     = q_ien[q] && del_hit && pend_fin;
    assign deassert_vec[q] = q_ien[q] && (drain_vec[q] || del_hit);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        head_r <= '0;
        tail_r <= '0;
      end else if (del_hit) begin
        head_r <= '0;
        tail_r <= '0;
      end else begin
        head_r <= head_b;
        tail_r <= tail_a;
      end
    end

    AST_DRAIN_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      drain_vec[q] |=> (head_r == tail_r)); // R4

    AST_DELETE_RESETS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      del_hit |=> (head_r == '0 && tail_r == '0)); // R6
  end
endmodule

// File: rtl/pinirq_counter.sv
module pinirq_counter #(
  parameter int MAX_CNT = 16,
  parameter int CNT_W   = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic [1:0]       dec_n,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next,
  output logic             err
);
  import pinirq_pkg::*;

  logic uf;

  always_comb begin
    cnt_next = CNT_W'(cnt_apply(32'(cnt), 32'(inc), 32'(dec_n)));
    uf       = cnt_underflow(32'(cnt), 32'(inc), 32'(dec_n));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      cnt <= cnt_next;
      if (uf) err <= 1'b1;
    end
  end

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec_n == 2'd0 && 32'(cnt) < MAX_CNT) |=> (32'(cnt) == 32'($past(cnt)) + 1)); // R2

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= MAX_CNT); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R9
endmodule

// File: rtl/pinirq_vec_status.sv
module pinirq_vec_status
  import pinirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_bits,
  input  logic [NUM_VEC-1:0] clr_bits,
  input  logic               clr_allowed,
  input  logic               mask_set_valid,
  input  logic [VEC_W-1:0]   mask_set_vec,
  input  logic               mask_clr_valid,
  input  logic [VEC_W-1:0]   mask_clr_vec,
  output logic [NUM_VEC-1:0] status,
  output logic               pin
);
  logic [NUM_VEC-1:0] mask_r, mask_n, status_n;

  always_comb begin
    status_n = (status | set_bits) & ~(clr_allowed ? clr_bits : '0);
    mask_n   = mask_r;
    if (mask_clr_valid) mask_n = mask_n & ~vec_bit(mask_clr_vec);
    if (mask_set_valid) mask_n = mask_n | vec_bit(mask_set_vec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask_r <= '0;
      pin    <= 1'b0;
    end else begin
      status <= status_n;
      mask_r <= mask_n;
      pin    <= |(status_n & ~mask_n);
    end
  end

  AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_allowed |=> ((status & $past(status)) == $past(status))); // R5

  AST_MASK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set_valid && mask_clr_valid && mask_set_vec == mask_clr_vec &&
     set_bits == '0 && clr_bits == '0) |=> !(status[$past(mask_set_vec)] && pin &&
     ((status & ~vec_bit($past(mask_set_vec))) == '0))); // R8
endmodule

// File: rtl/pinirq_aggr.sv
module pinirq_aggr #(
  parameter int NUM_Q = 16,
  parameter int IDX_W = 8,
  localparam int QID_W = $clog2(NUM_Q),
  localparam int CNT_W = $clog2(NUM_Q + 1),
  localparam int QV_W  = NUM_Q * pinirq_pkg::VEC_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           post_valid,
  input  logic [QID_W-1:0]               post_qid,
  input  logic [IDX_W-1:0]               post_tail,
  input  logic                           db_valid,
  input  logic [QID_W-1:0]               db_qid,
  input  logic [IDX_W-1:0]               db_head,
  input  logic                           del_valid,
  input  logic [QID_W-1:0]               del_qid,
  input  logic [NUM_Q-1:0]               q_ien,
  input  logic [QV_W-1:0]                q_vec,
  input  logic                           mask_set_valid,
  input  logic [pinirq_pkg::VEC_W-1:0]   mask_set_vec,
  input  logic                           mask_clr_valid,
  input  logic [pinirq_pkg::VEC_W-1:0]   mask_clr_vec,
  output logic [pinirq_pkg::NUM_VEC-1:0] irq_status,
  output logic                           irq_pin,
  output logic [CNT_W-1:0]               pend_cnt,
  output logic                           cnt_err
);
  import pinirq_pkg::*;

  // named internal events
  logic [NUM_Q-1:0]   rise_vec, hit_vec, drain_vec, delp_vec, deassert_vec;
  logic               cnt_inc;
  logic [1:0]         cnt_dec;
  logic [CNT_W-1:0]   cnt_next;
  logic               clr_ok;
  logic [NUM_VEC-1:0] set_bits, clr_bits;

  pinirq_cq_track #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .QID_W(QID_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .post_valid(post_valid), .post_qid(post_qid), .post_tail(post_tail),
    .db_valid(db_valid), .db_qid(db_qid), .db_head(db_head),
    .del_valid(del_valid), .del_qid(del_qid), .q_ien(q_ien),
    .rise_vec(rise_vec), .hit_vec(hit_vec), .drain_vec(drain_vec),
    .delp_vec(delp_vec), .deassert_vec(deassert_vec)
  );

  assign cnt_inc = |rise_vec;
  assign cnt_dec = 2'($countones(drain_vec) + $countones(delp_vec));

  pinirq_counter #(.MAX_CNT(NUM_Q), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .dec_n(cnt_dec),
    .cnt(pend_cnt), .cnt_next(cnt_next), .err(cnt_err)
  );

  assign clr_ok = (cnt_next == '0);

  always_comb begin
    set_bits = '0;
    clr_bits = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (hit_vec[q])      set_bits = set_bits | vec_bit(q_vec[q*VEC_W +: VEC_W]);
      if (deassert_vec[q]) clr_bits = clr_bits | vec_bit(q_vec[q*VEC_W +: VEC_W]);
    end
  end

  pinirq_vec_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_bits(set_bits), .clr_bits(clr_bits), .clr_allowed(clr_ok),
    .mask_set_valid(mask_set_valid), .mask_set_vec(mask_set_vec),
    .mask_clr_valid(mask_clr_valid), .mask_clr_vec(mask_clr_vec),
    .status(irq_status), .pin(irq_pin)
  );

  AST_POLLED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !q_ien[post_qid] && !db_valid && !del_valid) |=> (pend_cnt == $past(pend_cnt))); // R7

  AST_CLEAR_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_status & ~$past(irq_status)) == '0 && ($past(irq_status) & ~irq_status) != '0) |-> (pend_cnt == '0)); // R5
endmodule

// File: tb/pinirq_aggr_tb.sv
module pinirq_aggr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_valid = 1'b0, db_valid = 1'b0, del_valid = 1'b0;
  logic [3:0]  post_qid = '0, db_qid = '0, del_qid = '0;
  logic [7:0]  post_tail = '0, db_head = '0;
  logic [15:0] q_ien = 16'h00FF;
  logic [79:0] q_vec;
  logic        mask_set_valid = 1'b0, mask_clr_valid = 1'b0;
  logic [4:0]  mask_set_vec = '0, mask_clr_vec = '0;
  logic [31:0] irq_status;
  logic        irq_pin;
  logic [4:0]  pend_cnt;
  logic        cnt_err;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  // R11: queue q uses vector q mod 4
  always_comb for (int q = 0; q < 16; q++) q_vec[q*5 +: 5] = 5'(q % 4);

  pinirq_aggr u_dut (
    .clk(clk), .rst_n(rst_n),
    .post_valid(post_valid), .post_qid(post_qid), .post_tail(post_tail),
    .db_valid(db_valid), .db_qid(db_qid), .db_head(db_head),
    .del_valid(del_valid), .del_qid(del_qid),
    .q_ien(q_ien), .q_vec(q_vec),
    .mask_set_valid(mask_set_valid), .mask_set_vec(mask_set_vec),
    .mask_clr_valid(mask_clr_valid), .mask_clr_vec(mask_clr_vec),
    .irq_status(irq_status), .irq_pin(irq_pin), .pend_cnt(pend_cnt), .cnt_err(cnt_err)
  );

  typedef struct packed {
    logic       pv; logic [3:0] pq; logic [7:0] pt;
    logic       dv; logic [3:0] dq; logic [7:0] dh;
    logic [4:0] cnt; logic [31:0] st; logic pin;
  } step_t;

  localparam step_t TBL [11] = '{
    '{1'b1, 4'd0, 8'd3, 1'b0, 4'd0, 8'd0, 5'd1, 32'h1, 1'b1}, // R2 q0 fills
    '{1'b1, 4'd0, 8'd5, 1'b0, 4'd0, 8'd0, 5'd1, 32'h1, 1'b1}, // R3 repost
    '{1'b1, 4'd1, 8'd2, 1'b0, 4'd0, 8'd0, 5'd2, 32'h3, 1'b1}, // R2 q1 fills
    '{1'b0, 4'd0, 8'd0, 1'b1, 4'd0, 8'd3, 5'd2, 32'h3, 1'b1}, // R4 partial
    '{1'b0, 4'd0, 8'd0, 1'b1, 4'd0, 8'd5, 5'd1, 32'h3, 1'b1}, // R5 hold
    '{1'b1, 4'd9, 8'd4, 1'b0, 4'd0, 8'd0, 5'd1, 32'h3, 1'b1}, // R7 polled
    '{1'b0, 4'd0, 8'd0, 1'b1, 4'd1, 8'd2, 5'd0, 32'h1, 1'b1}, // R5 clears vec1
    '{1'b1, 4'd4, 8'd1, 1'b0, 4'd0, 8'd0, 5'd1, 32'h1, 1'b1}, // R2 q4
    '{1'b0, 4'd0, 8'd0, 1'b1, 4'd4, 8'd1, 5'd0, 32'h0, 1'b0}, // R5 clears vec0
    '{1'b1, 4'd2, 8'd7, 1'b1, 4'd2, 8'd7, 5'd0, 32'h0, 1'b0}, // R10 post+db
    '{1'b0, 4'd0, 8'd0, 1'b1, 4'd9, 8'd4, 5'd0, 32'h0, 1'b0}  // R7 polled drain
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [4:0] c, input logic [31:0] s, input logic p);
    check({req, " count"}, 32'(pend_cnt), 32'(c));
    check({req, " status"}, irq_status, s);
    check({req, " pin"}, 32'(irq_pin), 32'(p));
  endtask

  // drive at negedge, one posedge passes, sample at next negedge
  task automatic tick();
    @(negedge clk);
    post_valid = 0; db_valid = 0; del_valid = 0;
    mask_set_valid = 0; mask_clr_valid = 0;
  endtask

  task automatic do_post(input logic [3:0] q, input logic [7:0] t);
    post_valid = 1; post_qid = q; post_tail = t; tick();
  endtask
  task automatic do_db(input logic [3:0] q, input logic [7:0] h);
    db_valid = 1; db_qid = q; db_head = h; tick();
  endtask
  task automatic do_del(input logic [3:0] q);
    del_valid = 1; del_qid = q; tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset", 5'd0, 32'h0, 1'b0);
    check("R1 err", 32'(cnt_err), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      post_valid = TBL[i].pv; post_qid = TBL[i].pq; post_tail = TBL[i].pt;
      db_valid = TBL[i].dv; db_qid = TBL[i].dq; db_head = TBL[i].dh;
      tick();
      check_all($sformatf("table step %0d", i), TBL[i].cnt, TBL[i].st, TBL[i].pin);
    end
    check("R7 R4 no err", 32'(cnt_err), 0);

    // R8 mask
    do_post(4'd3, 8'd1);
    check_all("R2 q3", 5'd1, 32'h8, 1'b1);
    mask_set_valid = 1; mask_set_vec = 5'd3; tick();
    check_all("R8 masked", 5'd1, 32'h8, 1'b0);
    mask_clr_valid = 1; mask_clr_vec = 5'd3; tick();
    check("R8 unmasked pin", 32'(irq_pin), 1);
    mask_set_valid = 1; mask_clr_valid = 1; tick();
    check("R8 set wins pin", 32'(irq_pin), 0);
    mask_clr_valid = 1; tick();
    check("R8 unmask again pin", 32'(irq_pin), 1);

    // R6 delete pending queue, then confirm indices were zeroed
    do_del(4'd3);
    check_all("R6 del pending", 5'd0, 32'h0, 1'b0);
    do_post(4'd3, 8'd1);
    check_all("R6 idx reset", 5'd1, 32'h8, 1'b1);
    do_db(4'd3, 8'd1);
    check_all("R4 q3 drain", 5'd0, 32'h0, 1'b0);

    // R6 delete with other queues pending
    do_post(4'd0, 8'd6);
    check_all("R2 q0 again", 5'd1, 32'h1, 1'b1);
    do_post(4'd1, 8'd3);
    check_all("R2 q1 again", 5'd2, 32'h3, 1'b1);
    do_del(4'd1);
    check_all("R6 del hold", 5'd1, 32'h3, 1'b1);
    do_db(4'd0, 8'd6);
    check_all("R5 only own bit", 5'd0, 32'h2, 1'b1);
    do_del(4'd5);
    check_all("R6 del empty deasserts", 5'd0, 32'h0, 1'b0);
    check("R6 no err", 32'(cnt_err), 0);

    // R9 underflow via queue enabled after its post
    q_ien = 16'h00BF;
    do_post(4'd6, 8'd2);
    check_all("R7 q6 polled post", 5'd0, 32'h0, 1'b0);
    q_ien = 16'h00FF;
    do_db(4'd6, 8'd2);
    check("R9 err set", 32'(cnt_err), 1);
    check("R9 count held", 32'(pend_cnt), 0);
    tick();
    check("R9 err sticky", 32'(cnt_err), 1);

    // R1 reset again
    do_post(4'd2, 8'd9);
    rst_n = 0;
    tick(); tick();
    check_all("R1 reset2", 5'd0, 32'h0, 1'b0);
    check("R1 err cleared", 32'(cnt_err), 0);
    rst_n = 1;
    tick();
    do_post(4'd2, 8'd1);
    check_all("R1 queue empty after reset", 5'd1, 32'h4, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule